// File: doc/BRIEF.md
# Pipelined Overlay Switch Box

This block is the routing switch of an island-style virtual fabric that runs on top of a programmable device. It sits where four channels meet: north, east, south and west. Each channel carries a parameter number of multi-bit tracks. The tracks are logically bidirectional, but each one is built from one-way pieces. Every outgoing track has its own multiplexer, and that multiplexer picks one potential source and drives exactly one sink.

An outgoing track on one side can take one of two kinds of source. It can take the track with the same index from any of the other three sides, or it can take the local compute-unit output. It can also be left unused, in which case it drives zero.

Every outgoing track is registered. Each hop through the fabric therefore adds one pipeline stage, and no configuration can close a combinational loop.

The multiplexer selects come from a serial configuration chain. The chain segment passes its last bit on to the next switch box. While the chain is shifting, all output registers are held at zero.

Top module: `ovl_switch_box`

## Requirements
- R1: Each output track is registered. A change on a source appears on the output track one clock later, and never in the same cycle.
- R2: For an output on side s (N=0, E=1, S=2, W=3), select code c in 1..3 takes track t from side (s+c) mod 4. Code 4 takes `cu_i`.
- R3: Select code 0 drives zero on the output track. Codes 5 to 7 also drive zero.
- R4: An output track t only ever carries track t of another side. It never carries a different index, and never the input from its own side.
- R5: In every cycle that `cfg_en_i` is high, all output registers load zero. They capture their selected source again from the first rising clock edge that sees `cfg_en_i` low.
- R6: Each select field is SEL_W = 3 bits wide. Field f = side*NUM_TRACKS + track sits at chain bits [f*3 +: 3]. On each enabled clock edge the chain shifts one place toward higher bit positions and takes `cfg_di_i` into bit 0. So the first bit shifted in ends up as the MSB of the last field after 48 shifts (default parameters). `cfg_do_o` is the top chain bit.
- R7: While `cfg_en_i` is low, `cfg_di_i` is ignored and the loaded selects are kept.
- R8: After reset, all output tracks are zero, all select fields are zero and `cfg_do_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Configuration shift enable |
| cfg_di_i | input | 1 | Serial configuration data in |
| cfg_do_o | output | 1 | Serial configuration data out, to the next chain segment |
| cu_i | input | TRACK_W | Local compute-unit output |
| trk_i | input | 4*NUM_TRACKS*TRACK_W | Incoming tracks; track t of side s sits at slice (s*NUM_TRACKS+t)*TRACK_W |
| trk_o | output | 4*NUM_TRACKS*TRACK_W | Registered outgoing tracks, packed the same way |

## Verification
The bench loads select patterns that rotate through every code on every side. This exposes a rotated or mirrored side mapping, or a track that reads the wrong index, as a mismatch against the reference model on that track.

Codes 5 to 7 are loaded deliberately. A multiplexer that decodes only the low bits would pass data through on those codes instead of driving zero.

Outputs are compared on every cycle of a shift burst and on the first cycle after it. This catches a design that fails to clear during shifting, or that clears one cycle late.

The chain output is compared on every cycle across a second full shift, and `cfg_di_i` is toggled while the enable is low. A reversed field order or bit order, a missing shift stage, or an enable leak would each show up as a corrupted select value or a wrong serial stream.

// File: rtl/ovl_sbox_pkg.sv
package ovl_sbox_pkg;
  typedef enum logic [1:0] {
    SIDE_N = 2'd0,
    SIDE_E = 2'd1,
    SIDE_S = 2'd2,
    SIDE_W = 2'd3
  } side_e;

  localparam int unsigned NUM_SIDES = 4;
  // three foreign sides plus the local compute output
  localparam int unsigned NUM_SRC   = NUM_SIDES;

  function automatic int unsigned src_side(input int unsigned out_side, input int unsigned code);
    return (out_side + code) % NUM_SIDES;
  endfunction
endpackage

// File: rtl/sbox_cfg_chain.sv
module sbox_cfg_chain #(
  parameter int unsigned NUM_FIELDS = 16,
  parameter int unsigned SEL_W      = 3,
  localparam int unsigned CFG_BITS  = NUM_FIELDS * SEL_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_en_i,
  input  logic                cfg_di_i,
  output logic                cfg_do_o,
  output logic [CFG_BITS-1:0] sel_o
);
  logic [CFG_BITS-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       chain_q <= '0;
    else if (cfg_en_i) chain_q <= {chain_q[CFG_BITS-2:0], cfg_di_i};
  end

  assign sel_o    = chain_q;
  assign cfg_do_o = chain_q[CFG_BITS-1];

  p_shift_in_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> chain_q[0] == $past(cfg_di_i));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> $stable(chain_q));
endmodule

// File: rtl/sbox_track.sv
module sbox_track #(
  parameter int unsigned TRACK_W = 16,
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned NUM_SRC = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cfg_en_i,
  input  logic [SEL_W-1:0]           sel_i,
  input  logic [NUM_SRC*TRACK_W-1:0] src_i,
  output logic [TRACK_W-1:0]         q_o
);
  logic [TRACK_W-1:0] nxt;

  // code k+1 picks source k, anything else leaves the track unused
  always_comb begin
    nxt = '0;
    for (int unsigned k = 0; k < NUM_SRC; k++) begin
      if (sel_i == SEL_W'(k + 1)) nxt = src_i[k*TRACK_W +: TRACK_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= '0;
    else if (cfg_en_i) q_o <= '0;
    else               q_o <= nxt;
  end

  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> q_o == '0);

  p_unused_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_en_i && (sel_i == '0 || sel_i > SEL_W'(NUM_SRC))) |=> q_o == '0);

  p_cu_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_en_i && sel_i == SEL_W'(NUM_SRC))
      |=> q_o == $past(src_i[(NUM_SRC-1)*TRACK_W +: TRACK_W]));

  p_first_src_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_en_i && sel_i == SEL_W'(1)) |=> q_o == $past(src_i[TRACK_W-1:0]));
endmodule

// File: rtl/ovl_switch_box.sv
module ovl_switch_box
  import ovl_sbox_pkg::*;
#(
  parameter int unsigned NUM_TRACKS = 4,
  parameter int unsigned TRACK_W    = 16,
  localparam int unsigned SEL_W      = $clog2(NUM_SRC + 1),
  localparam int unsigned NUM_FIELDS = NUM_SIDES * NUM_TRACKS,
  localparam int unsigned CFG_BITS   = NUM_FIELDS * SEL_W,
  localparam int unsigned BUS_W      = NUM_FIELDS * TRACK_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_en_i,
  input  logic               cfg_di_i,
  output logic               cfg_do_o,
  input  logic [TRACK_W-1:0] cu_i,
  input  logic [BUS_W-1:0]   trk_i,
  output logic [BUS_W-1:0]   trk_o
);
  logic [CFG_BITS-1:0] sel;

  sbox_cfg_chain #(
    .NUM_FIELDS(NUM_FIELDS),
    .SEL_W     (SEL_W)
  ) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cfg_en_i(cfg_en_i),
    .cfg_di_i(cfg_di_i),
    .cfg_do_o(cfg_do_o),
    .sel_o   (sel)
  );

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    for (genvar t = 0; t < NUM_TRACKS; t++) begin : g_trk
      localparam int unsigned FLD = s * NUM_TRACKS + t;
      logic [NUM_SRC*TRACK_W-1:0] src;

      for (genvar k = 0; k < NUM_SRC - 1; k++) begin : g_src
        localparam int unsigned SIDE = src_side(s, k + 1);
        assign src[k*TRACK_W +: TRACK_W] = trk_i[(SIDE*NUM_TRACKS + t)*TRACK_W +: TRACK_W];
      end
      assign src[(NUM_SRC-1)*TRACK_W +: TRACK_W] = cu_i;

      sbox_track #(
        .TRACK_W(TRACK_W),
        .SEL_W  (SEL_W),
        .NUM_SRC(NUM_SRC)
      ) u_track (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .cfg_en_i(cfg_en_i),
        .sel_i   (sel[FLD*SEL_W +: SEL_W]),
        .src_i   (src),
        .q_o     (trk_o[FLD*TRACK_W +: TRACK_W])
      );
    end
  end

  p_cfg_out_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> $stable(cfg_do_o));
endmodule

// File: tb/ovl_switch_box_tb_top.sv
`timescale 1ns/1ps
module ovl_switch_box_tb_top;
  localparam int NT = 4;
  localparam int W  = 16;
  localparam int NS = 4;
  localparam int SW = 3;
  localparam int NF = NS * NT;
  localparam int CB = NF * SW;

  logic clk = 0;
  logic rst_n = 0;
  logic cfg_en = 0, cfg_di = 0;
  logic [W-1:0] cu = '0;
  logic [W-1:0] tin [NS][NT];
  logic [NF*W-1:0] trk_in, trk_out;
  logic cfg_do;

  int checks = 0, fails = 0;
  string cur_req = "R1";

  logic [CB-1:0] m_chain;
  logic [W-1:0]  m_out [NS][NT];
  logic          m_do;
  int            codes [NF];

  always #2 clk = ~clk;

  always_comb
    for (int f = 0; f < NF; f++) trk_in[f*W +: W] = tin[f/NT][f%NT];

  ovl_switch_box #(.NUM_TRACKS(NT), .TRACK_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(cfg_en), .cfg_di_i(cfg_di),
    .cfg_do_o(cfg_do), .cu_i(cu), .trk_i(trk_in), .trk_o(trk_out)
  );

  function automatic logic [W-1:0] pick(int s, int t, int c);
    if (c >= 1 && c <= 3) return tin[(s + c) % NS][t];
    if (c == 4) return cu;
    return '0;
  endfunction

  // reference model, built from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_chain = '0;
      for (int s = 0; s < NS; s++) for (int t = 0; t < NT; t++) m_out[s][t] = '0;
    end else begin
      for (int s = 0; s < NS; s++)
        for (int t = 0; t < NT; t++)
          m_out[s][t] = cfg_en ? '0 : pick(s, t, int'(m_chain[(s*NT+t)*SW +: SW]));
      if (cfg_en) m_chain = {m_chain[CB-2:0], cfg_di};
    end
    m_do = m_chain[CB-1];
  end

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h @%0t", req, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) if (rst_n) begin
    for (int f = 0; f < NF; f++) chk(cur_req, trk_out[f*W +: W], m_out[f/NT][f%NT]);
    chk("R6", W'(cfg_do), W'(m_do));
  end

  task automatic shift_codes();
    for (int f = NF - 1; f >= 0; f--)
      for (int b = SW - 1; b >= 0; b--) begin
        @(negedge clk); cfg_en = 1; cfg_di = codes[f][b];
      end
    @(negedge clk); cfg_en = 0; cfg_di = 0;
  endtask

  task automatic rand_inputs(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cu = W'($urandom);
      for (int s = 0; s < NS; s++) for (int t = 0; t < NT; t++) tin[s][t] = W'($urandom);
    end
  endtask

  task automatic run();
    for (int s = 0; s < NS; s++) for (int t = 0; t < NT; t++) tin[s][t] = '0;
    #5;
    // R8: reset state
    chk("R8", trk_out[W-1:0], '0);
    chk("R8", W'(cfg_do), '0);
    rst_n = 1;
    @(negedge clk);
    chk("R8", trk_out[NF*W-1 -: W], '0);

    // R2: all tracks take the compute output
    cur_req = "R2";
    for (int f = 0; f < NF; f++) codes[f] = 4;
    shift_codes();
    @(negedge clk); cu = 16'hA5A5;
    @(negedge clk);
    chk("R2", trk_out[5*W +: W], 16'hA5A5);
    rand_inputs(20);

    // R2/R4: rotating side selections
    cur_req = "R4";
    for (int f = 0; f < NF; f++) codes[f] = 1 + ((f + f/NT) % 3);
    shift_codes();
    rand_inputs(40);
    // field 0 (N, track 0) has code 1 -> east track 0
    @(negedge clk); tin[1][0] = 16'h1234; tin[0][0] = 16'hFFFF;
    chk("R1", trk_out[0 +: W] == 16'h1234 ? 16'h0 : 16'h1, 16'h1); // not yet visible
    @(negedge clk);
    chk("R1", trk_out[0 +: W], 16'h1234);

    // R3: unused and out-of-range codes
    cur_req = "R3";
    for (int f = 0; f < NF; f++) codes[f] = (f % 4 == 0) ? 0 : 4 + (f % 4);
    shift_codes();
    rand_inputs(20);
    chk("R3", trk_out[3*W +: W], '0);

    // R5/R6: second full shift, clear during shift, chain out stream
    cur_req = "R5";
    for (int f = 0; f < NF; f++) codes[f] = (f * 5 + 1) % 8;
    shift_codes();
    chk("R5", trk_out[0 +: W], m_out[0][0]);
    rand_inputs(20);

    // R7: cfg_di ignored while cfg_en low
    cur_req = "R7";
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); cfg_di = ~cfg_di; cu = W'($urandom); tin[2][1] = W'($urandom);
    end
    cfg_di = 0;
    rand_inputs(10);
    @(negedge clk);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule